// File: doc/BRIEF.md
# General-Purpose Event Register Bank

This block holds a small bank of general-purpose event flags and their enable masks. It sits on a byte-addressed I/O bus at a fixed base address and answers a four-byte window there. Hotplug sources, and other sources of events, raise single-cycle set pulses on a vector input. Each pulse latches a status flag. Software reads the flags, masks them with enable bits and clears them by writing ones. A level interrupt output, the system control interrupt, is high whenever any latched flag is also enabled.

A bus access names its lowest byte address and carries up to four byte strobes. Strobe lane k refers to byte address addr+k. Data lane k is bits 8k+7:8k, so the ordering is little-endian. Every strobed lane is handled as a separate byte operation. A lane whose byte address falls outside the window is dropped. An access may therefore be partly inside the window and partly outside it. The interrupt level is registered, and the same clock edge that commits a write or an event updates it.

Top module: `gpe_event_bank`

## Requirements
- R1: Only byte addresses BASE_ADDR to BASE_ADDR+3 (default 0xAFE0 to 0xAFE3) are decoded. A strobed lane at any other byte address changes no state and reads as 0x00.
- R2: Strobe io_be_i[k] selects byte address io_addr_i+k, and that byte travels on data bits 8k+7:8k. Any pattern of 1 to 4 strobes is accepted, at any start address.
- R3: Window offset 0 holds status bits 7:0 and offset 1 holds status bits 15:8. Offset 2 holds enable bits 7:0 and offset 3 holds enable bits 15:8.
- R4: Writing a 1 to a status bit clears it at the next clock edge. Writing a 0 leaves it unchanged. Software can never set a status bit.
- R5: Enable bits are plain read/write. A written byte replaces that enable byte at the next edge, and enable bytes that are not written hold their value.
- R6: A high evt_set_i[i] in a cycle sets status bit i at the next clock edge.
- R7: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R8: After every clock edge, sci_o equals the OR over i of status[i] AND enable[i]. A write or an event is therefore reflected in sci_o from the edge that commits it.
- R9: While rst_ni is low, and after it is released, all status and enable bits are 0 and sci_o is 0.
- R10: io_rdata_o is combinational from the current state. A lane reads 0x00 unless io_rd_i is high, its strobe is set and its byte address is inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | Byte address of lane 0 |
| io_be_i | input | 4 | Byte strobes, lane k is io_addr_i+k |
| io_wr_i | input | 1 | Write request |
| io_rd_i | input | 1 | Read request |
| io_wdata_i | input | 32 | Write data, little-endian lanes |
| io_rdata_o | output | 32 | Read data, little-endian lanes |
| evt_set_i | input | 16 | Event set pulses, one per status bit |
| sci_o | output | 1 | Level interrupt request |

## Verification
A status bit can receive an event set and a software write-one-to-clear in the same cycle. How the bank resolves this collision is the main risk. The bench provokes it in two ways. In a directed case it fires an event on the same bit that a strobed write is clearing. It also runs a long random phase in which event pulses and unaligned writes, partly inside and partly outside the window, hit the status bytes together. A behavioural byte-array model applies the clear first and the set second. Its read data and interrupt level are compared with the design on every cycle.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  typedef logic [LANE_W-1:0] byte_t;
endpackage

// File: rtl/gpe_lane_decode.sv
module gpe_lane_decode
  import gpe_pkg::*;
#(
  parameter int unsigned          ADDR_W = 16,
  parameter logic [ADDR_W-1:0]    BASE   = 16'hAFE0,
  parameter int unsigned          WIN    = 4,
  localparam int unsigned         OFF_W  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [LANES-1:0]             be_i,
  input  logic                         wr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [LANES-1:0]             lane_hit_o,
  output logic [LANES-1:0][OFF_W-1:0]  lane_off_o,
  output logic [WIN-1:0]               byte_we_o,
  output logic [WIN-1:0][LANE_W-1:0]   byte_wdata_o
);
  localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE};
  localparam logic [ADDR_W:0] LIM_X  = BASE_X + (ADDR_W+1)'(WIN);

  // per-lane byte address, widened so addr+k never wraps into the window
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0] lane_addr;
    assign lane_addr     = {1'b0, addr_i} + (ADDR_W+1)'(k);
    assign lane_hit_o[k] = be_i[k] && (lane_addr >= BASE_X) && (lane_addr < LIM_X);
    assign lane_off_o[k] = OFF_W'(lane_addr - BASE_X);
  end

  always_comb begin
    byte_we_o    = '0;
    byte_wdata_o = '0;
    for (int r = 0; r < WIN; r++) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_i && lane_hit_o[k] && (int'(lane_off_o[k]) == r)) begin
          byte_we_o[r]    = 1'b1;
          byte_wdata_o[r] = wdata_i[k*LANE_W +: LANE_W];
        end
      end
    end
  end

  // distinct lanes always map to distinct window bytes
  for (genvar r = 0; r < WIN; r++) begin : g_chk
    logic [LANES-1:0] hits;
    for (genvar k = 0; k < LANES; k++) begin : g_h
      assign hits[k] = lane_hit_o[k] && (int'(lane_off_o[k]) == r);
    end
    always_comb begin
      assert_one_lane_per_byte_R2: assert (!$isunknown(hits) -> $onehot0(hits));
    end
  end
endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank
  import gpe_pkg::*;
#(
  parameter int unsigned  NBYTES = 2,
  localparam int unsigned BITS   = NBYTES * LANE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NBYTES-1:0]           we_i,
  input  logic [NBYTES-1:0][LANE_W-1:0] wdata_i,
  input  logic [BITS-1:0]             set_i,
  output logic [BITS-1:0]             sts_o,
  output logic [BITS-1:0]             sts_d_o
);
  logic [BITS-1:0] clr_mask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_clr
    assign clr_mask[b*LANE_W +: LANE_W] = we_i[b] ? wdata_i[b] : '0;
  end

  // clear first, set second: an event wins over a same-cycle clear
  assign sts_d_o = (sts_o & ~clr_mask) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= sts_d_o;
  end

  assert_event_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~sts_o) == '0));

  assert_no_sw_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_o & ~$past(sts_o) & ~$past(set_i)) == '0));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|we_i) && !(|set_i)) |=> $stable(sts_o));
endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank
  import gpe_pkg::*;
#(
  parameter int unsigned  NBYTES = 2,
  localparam int unsigned BITS   = NBYTES * LANE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NBYTES-1:0]             we_i,
  input  logic [NBYTES-1:0][LANE_W-1:0] wdata_i,
  output logic [BITS-1:0]               en_o,
  output logic [BITS-1:0]               en_d_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign en_d_o[b*LANE_W +: LANE_W] = we_i[b] ? wdata_i[b] : en_o[b*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else         en_o <= en_d_o;
  end

  assert_en_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|we_i) |=> $stable(en_o));
endmodule

// File: rtl/gpe_event_bank.sv
module gpe_event_bank
  import gpe_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'hAFE0,
  parameter int unsigned       HALF_BYTES = 2,
  localparam int unsigned      WIN        = 2 * HALF_BYTES,
  localparam int unsigned      EVT_BITS   = HALF_BYTES * LANE_W,
  localparam int unsigned      OFF_W      = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   io_addr_i,
  input  logic [LANES-1:0]    io_be_i,
  input  logic                io_wr_i,
  input  logic                io_rd_i,
  input  logic [DATA_W-1:0]   io_wdata_i,
  output logic [DATA_W-1:0]   io_rdata_o,
  input  logic [EVT_BITS-1:0] evt_set_i,
  output logic                sci_o
);
  logic [LANES-1:0]            lane_hit;
  logic [LANES-1:0][OFF_W-1:0] lane_off;
  logic [WIN-1:0]              byte_we;
  logic [WIN-1:0][LANE_W-1:0]  byte_wdata;
  logic [EVT_BITS-1:0]         sts_q, sts_d, en_q, en_d;
  logic [WIN-1:0][LANE_W-1:0]  win_bytes;

  gpe_lane_decode #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR), .WIN(WIN)) u_dec (
    .addr_i       (io_addr_i),
    .be_i         (io_be_i),
    .wr_i         (io_wr_i),
    .wdata_i      (io_wdata_i),
    .lane_hit_o   (lane_hit),
    .lane_off_o   (lane_off),
    .byte_we_o    (byte_we),
    .byte_wdata_o (byte_wdata)
  );

  // low half of the window is status, high half is enable
  gpe_status_bank #(.NBYTES(HALF_BYTES)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (byte_we[HALF_BYTES-1:0]),
    .wdata_i (byte_wdata[HALF_BYTES-1:0]),
    .set_i   (evt_set_i),
    .sts_o   (sts_q),
    .sts_d_o (sts_d)
  );

  gpe_enable_bank #(.NBYTES(HALF_BYTES)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (byte_we[WIN-1:HALF_BYTES]),
    .wdata_i (byte_wdata[WIN-1:HALF_BYTES]),
    .en_o    (en_q),
    .en_d_o  (en_d)
  );

  // level re-evaluated on the edge that commits any write or event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_o <= 1'b0;
    else         sci_o <= |(sts_d & en_d);
  end

  for (genvar b = 0; b < HALF_BYTES; b++) begin : g_win
    assign win_bytes[b]            = sts_q[b*LANE_W +: LANE_W];
    assign win_bytes[HALF_BYTES+b] = en_q[b*LANE_W +: LANE_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign io_rdata_o[k*LANE_W +: LANE_W] =
      (io_rd_i && lane_hit[k]) ? win_bytes[lane_off[k]] : '0;
  end

  assert_sci_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (sci_o == |(sts_q & en_q)));

  assert_miss_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && !(|lane_hit)) |=> $stable(en_q));

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == '0));
endmodule

// File: tb/sim_gpe_event_bank.sv
`timescale 1ns/1ps
module sim_gpe_event_bank;
  localparam int BASE = 'hAFE0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [3:0]  io_be_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [31:0] io_wdata_i = '0;
  logic [31:0] io_rdata_o;
  logic [15:0] evt_set_i = '0;
  logic        sci_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m [4];   // model window bytes: 0,1 status; 2,3 enable

  always #2 clk_i = ~clk_i;

  gpe_event_bank u0 (.*);

  function automatic logic [31:0] model_read(int addr, logic [3:0] be, logic rd);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) begin
      int a = addr + k;
      if (rd && be[k] && a >= BASE && a < BASE + 4) v[k*8 +: 8] = 8'(m[a - BASE]);
    end
    return v;
  endfunction

  function automatic logic model_sci();
    logic [15:0] s = {8'(m[1]), 8'(m[0])};
    logic [15:0] e = {8'(m[3]), 8'(m[2])};
    return |(s & e);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge
  task automatic step(logic wr, logic rd, int addr, logic [3:0] be, logic [31:0] wd,
                      logic [15:0] evt, string req);
    io_wr_i = wr; io_rd_i = rd; io_addr_i = 16'(addr); io_be_i = be;
    io_wdata_i = wd; evt_set_i = evt;
    #1;
    check({req, " rdata"}, io_rdata_o, model_read(addr, be, rd));
    if (wr) begin
      for (int k = 0; k < 4; k++) begin
        int a = addr + k;
        if (be[k] && a >= BASE && a < BASE + 4) begin
          int o = a - BASE;
          if (o < 2) m[o] = m[o] & ~int'(wd[k*8 +: 8]);
          else       m[o] = int'(wd[k*8 +: 8]);
        end
      end
    end
    m[0] = m[0] | int'(evt[7:0]);
    m[1] = m[1] | int'(evt[15:8]);
    @(posedge clk_i); @(negedge clk_i);
    io_wr_i = 1'b0; io_rd_i = 1'b0; evt_set_i = '0;
    check({req, " sci"}, {31'd0, sci_o}, {31'd0, model_sci()});
  endtask

  task automatic read_all(string req);
    step(1'b0, 1'b1, BASE, 4'hF, '0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(negedge clk_i);
    check("R9 sci in reset", {31'd0, sci_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_all("R9 reset state");

    // R5/R3: enable via 16-bit write at offset 2
    step(1'b1, 1'b0, BASE + 2, 4'b0011, 32'h0000_8001, '0, "R5 enable write");
    read_all("R3 layout");
    // R6: event on an enabled bit raises sci
    step(1'b0, 1'b0, BASE, 4'h0, '0, 16'h0001, "R6 event set");
    read_all("R8 sci after event");
    // R6: event on a masked bit alone
    step(1'b0, 1'b0, BASE, 4'h0, '0, 16'h0100, "R6 masked event");
    // R4: writing zero leaves bits, writing one clears
    step(1'b1, 1'b0, BASE, 4'b0001, 32'h0000_0000, '0, "R4 write zero");
    step(1'b1, 1'b0, BASE, 4'b0001, 32'h0000_0001, '0, "R4 clear");
    read_all("R4 readback");
    // R7: set and clear on the same bit in one cycle
    step(1'b1, 1'b0, BASE, 4'b0010, 32'h0000_FF00, 16'h8000, "R7 set wins");
    read_all("R7 readback");
    // R2: unaligned write, lane 3 falls outside the window
    step(1'b1, 1'b0, BASE + 1, 4'hF, 32'h77_5A_A5_80, '0, "R2 unaligned");
    read_all("R2 readback");
    // R2: start below base, lanes 2,3 land on offsets 0,1
    step(1'b1, 1'b1, BASE - 2, 4'hF, 32'hFFFF_0000, 16'h0004, "R2 below base");
    // R1: fully outside window
    step(1'b1, 1'b1, BASE + 4, 4'hF, 32'hFFFF_FFFF, '0, "R1 outside write");
    step(1'b1, 1'b0, BASE - 4, 4'hF, 32'h0000_0000, '0, "R1 outside low");
    read_all("R1 readback");
    // R10: strobes gate read lanes
    step(1'b0, 1'b1, BASE + 2, 4'b0010, '0, '0, "R10 single lane read");
    step(1'b0, 1'b0, BASE, 4'hF, '0, '0, "R10 no read");

    for (int i = 0; i < 2000; i++) begin
      int a = BASE - 3 + int'($urandom_range(0, 7));
      logic [15:0] ev = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : '0;
      step(1'($urandom), 1'($urandom), a, 4'($urandom), $urandom, ev, "R7 random collide");
    end
    read_all("R8 final");

    rst_ni = 1'b0; #1;
    for (int i = 0; i < 4; i++) m[i] = 0;
    check("R9 async reset sci", {31'd0, sci_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    read_all("R9 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule